// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block collects the small control and status registers that sit beside an I/O controller in a workstation. It has a configuration byte, a diagnostic byte, a modem-control byte, a 16-bit LED register, a system-control word and two auxiliary bytes. A bus master reaches them through a register-select code, an offset, a strobe, a write flag and a data bus. Read data is registered.

Several writes have side effects instead of plain storage. A set bit in the first auxiliary byte fires a one-cycle terminal-count strobe for a floppy controller, and that bit is not kept. The second auxiliary byte carries a software power-off request and a latched power-fail status. The power-fail status drives a level interrupt while it is enabled, and a write-one bit clears it. A reset-request write to the system-control word pulses a reset request and leaves a reset-status flag. That flag survives the soft reset the request causes, because the soft reset clears only part of the register set. A separate power-on reset clears everything.

Top module: `aux_sysctl_regs`

## Requirements
- R1: `acc_sel` picks the register: 0 config, 1 diagnostic, 2 modem control, 3 LED, 4 system control, 5 aux1, 6 aux2. Code 7 reads 0 and ignores writes. Only offset 0 of each register responds: a write at a non-zero `acc_off` changes nothing, and a read there returns 0.
- R2: A read (`acc_en`=1, `acc_wr`=0) puts the stored value, zero-extended, on `acc_rdata` in the cycle after the strobe. The value then holds until the next read. A read has no side effect.
- R3: Config, diagnostic and modem control store `acc_wdata[7:0]`. The LED register stores `acc_wdata[15:0]`.
- R4: An aux1 write stores the written byte with bit 1 forced to 0. When written bit 1 is 1, `tc_pulse_o` is high for exactly the one cycle after the write.
- R5: An aux2 write forms v = (wdata & 0x03) | (aux2 & 0x20). If v bit 1 is set, v becomes v & 0x01. v is stored, so aux2 only ever holds bits 0 and 5.
- R6: When the stored aux2 bit 0 is set by a write, `shutdown_req_o` is high for the one cycle after that write.
- R7: On a cycle where `pwr_fail_in` differs from its value in the previous cycle, aux2 bit 5 becomes `pwr_fail_in` AND config bit 3. This event is applied after any aux2 write in the same cycle.
- R8: `irq_o` equals aux2 bit 5 AND config bit 3. It follows the registers from the same clock edge at which they change.
- R9: A system-control write at offset 0 with bit 0 set stores 0x02 and pulses `sysrst_req_o` for one cycle. A write with bit 0 clear changes nothing.
- R10: While `rst` is high, config, aux1, aux2 and modem control clear to 0, the output pulses and `acc_rdata` clear, and accesses are ignored. The diagnostic, system-control and LED registers keep their values.
- R11: `por` clears every register and output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Soft block reset, synchronous, active high |
| por | input | 1 | Power-on reset, synchronous, active high |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Register select code |
| acc_off | input | 2 | Offset within the selected register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| pwr_fail_in | input | 1 | Power-fail indication |
| irq_o | output | 1 | Power-fail interrupt, level |
| tc_pulse_o | output | 1 | Terminal-count strobe |
| shutdown_req_o | output | 1 | Software power-off request pulse |
| sysrst_req_o | output | 1 | System reset request pulse |

## Verification
A wrong aux2 state shows up at the ports in two ways. `irq_o` goes wrong at the same edge the state goes wrong, and an aux2 read one cycle later shows the bad value. A terminal-count bit that is stored instead of dropped, or a missing strobe, is visible on the aux1 readback or on `tc_pulse_o` in the cycle after the write. The sweeps write every byte value to the byte registers. The power-fail state is re-latched during the aux2 sweep so that the clear and keep paths are both reached. Retention over a soft reset is checked by reading back the diagnostic, system-control and LED values after `rst` drops.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;
  localparam int NUM_REGS = 7;

  typedef enum logic [2:0] {
    SEL_CFG    = 3'd0,
    SEL_DIAG   = 3'd1,
    SEL_MODEM  = 3'd2,
    SEL_LED    = 3'd3,
    SEL_SYSCTL = 3'd4,
    SEL_AUX1   = 3'd5,
    SEL_AUX2   = 3'd6
  } reg_sel_e;

  // bit positions that neighbouring logic decodes
  localparam int CFG_PFEN_BIT  = 3;
  localparam int AUX1_TC_BIT   = 1;
  localparam int AUX2_OFF_BIT  = 0;
  localparam int AUX2_CLR_BIT  = 1;
  localparam int AUX2_PF_BIT   = 5;
  localparam int SYS_REQ_BIT   = 0;
  localparam logic [7:0] SYS_STAT_VAL = 8'h02;
endpackage

// File: rtl/aux_access_dec.sv
module aux_access_dec #(
  parameter int SEL_W = 3,
  parameter int OFF_W = 2,
  parameter int NREG  = 7
) (
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [SEL_W-1:0] acc_sel,
  input  logic [OFF_W-1:0] acc_off,
  input  logic             blk,
  output logic [NREG-1:0]  wr_hit,
  output logic             rd_hit
);
  logic base_ok;
  assign base_ok = acc_en & ~blk & (acc_off == '0);
  assign rd_hit  = acc_en & ~acc_wr & ~blk;

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign wr_hit[i] = base_ok & acc_wr & (acc_sel == SEL_W'(i));
  end
endmodule

// File: rtl/aux_pwr_ctl.sv
module aux_pwr_ctl
  import aux_sysctl_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por,
  input  logic             aux2_we,
  input  logic [1:0]       aux2_wbits,
  input  logic             cfg_we,
  input  logic             cfg_pfen_wr,
  input  logic             cfg_pfen,
  input  logic             pwr_fail_in,
  output logic [REG_W-1:0] aux2_q,
  output logic             irq_o,
  output logic             shutdown_o
);
  logic             pf_prev;
  logic [REG_W-1:0] wr_val;
  logic [REG_W-1:0] aux2_n;
  logic             pfen_n;

  always_comb begin
    wr_val = '0;
    wr_val[1:0] = aux2_wbits;
    wr_val[AUX2_PF_BIT] = aux2_q[AUX2_PF_BIT];
    if (wr_val[AUX2_CLR_BIT]) begin
      wr_val = '0;
      wr_val[AUX2_OFF_BIT] = aux2_wbits[AUX2_OFF_BIT];
    end
    aux2_n = aux2_we ? wr_val : aux2_q;
    if (pwr_fail_in != pf_prev)
      aux2_n[AUX2_PF_BIT] = pwr_fail_in & cfg_pfen;
    pfen_n = cfg_we ? cfg_pfen_wr : cfg_pfen;
  end

  always_ff @(posedge clk) begin
    if (por) pf_prev <= 1'b0;
    else     pf_prev <= pwr_fail_in;
  end

  always_ff @(posedge clk) begin
    if (rst || por) begin
      aux2_q     <= '0;
      irq_o      <= 1'b0;
      shutdown_o <= 1'b0;
    end else begin
      aux2_q     <= aux2_n;
      irq_o      <= aux2_n[AUX2_PF_BIT] & pfen_n;
      shutdown_o <= aux2_we & wr_val[AUX2_OFF_BIT];
    end
  end
endmodule

// File: rtl/aux_rd_mux.sv
module aux_rd_mux
  import aux_sysctl_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 32,
  parameter int REG_W  = 8,
  parameter int LED_W  = 16
) (
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [REG_W-1:0]  cfg_q,
  input  logic [REG_W-1:0]  diag_q,
  input  logic [REG_W-1:0]  modem_q,
  input  logic [LED_W-1:0]  led_q,
  input  logic [REG_W-1:0]  sysctl_q,
  input  logic [REG_W-1:0]  aux1_q,
  input  logic [REG_W-1:0]  aux2_q,
  output logic [DATA_W-1:0] rd_val
);
  always_comb begin
    rd_val = '0;
    if (acc_off == '0) begin
      case (acc_sel)
        SEL_CFG:    rd_val = DATA_W'(cfg_q);
        SEL_DIAG:   rd_val = DATA_W'(diag_q);
        SEL_MODEM:  rd_val = DATA_W'(modem_q);
        SEL_LED:    rd_val = DATA_W'(led_q);
        SEL_SYSCTL: rd_val = DATA_W'(sysctl_q);
        SEL_AUX1:   rd_val = DATA_W'(aux1_q);
        SEL_AUX2:   rd_val = DATA_W'(aux2_q);
        default:    rd_val = '0;
      endcase
    end
  end
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_sysctl_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 32,
  parameter int REG_W  = 8,
  parameter int LED_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic              pwr_fail_in,
  output logic              irq_o,
  output logic              tc_pulse_o,
  output logic              shutdown_req_o,
  output logic              sysrst_req_o
);
  localparam int NREG = NUM_REGS;

  logic [NREG-1:0]   wr_hit;
  logic              rd_hit;
  logic [REG_W-1:0]  cfg_q, diag_q, modem_q, sysctl_q, aux1_q, aux2_q;
  logic [LED_W-1:0]  led_q;
  logic [DATA_W-1:0] rd_val;
  logic [REG_W-1:0]  wbyte;
  logic              wdata_unused;

  assign wbyte        = acc_wdata[REG_W-1:0];
  assign wdata_unused = ^acc_wdata[DATA_W-1:LED_W];

  aux_access_dec #(.SEL_W(SEL_W), .OFF_W(OFF_W), .NREG(NREG)) u_dec (
    .acc_en (acc_en),
    .acc_wr (acc_wr),
    .acc_sel(acc_sel),
    .acc_off(acc_off),
    .blk    (rst | por),
    .wr_hit (wr_hit),
    .rd_hit (rd_hit)
  );

  aux_pwr_ctl #(.REG_W(REG_W)) u_pwr (
    .clk        (clk),
    .rst        (rst),
    .por        (por),
    .aux2_we    (wr_hit[SEL_AUX2]),
    .aux2_wbits (wbyte[1:0]),
    .cfg_we     (wr_hit[SEL_CFG]),
    .cfg_pfen_wr(wbyte[CFG_PFEN_BIT]),
    .cfg_pfen   (cfg_q[CFG_PFEN_BIT]),
    .pwr_fail_in(pwr_fail_in),
    .aux2_q     (aux2_q),
    .irq_o      (irq_o),
    .shutdown_o (shutdown_req_o)
  );

  aux_rd_mux #(.SEL_W(SEL_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
               .REG_W(REG_W), .LED_W(LED_W)) u_rd (
    .acc_sel (acc_sel),
    .acc_off (acc_off),
    .cfg_q   (cfg_q),
    .diag_q  (diag_q),
    .modem_q (modem_q),
    .led_q   (led_q),
    .sysctl_q(sysctl_q),
    .aux1_q  (aux1_q),
    .aux2_q  (aux2_q),
    .rd_val  (rd_val)
  );

  // registers cleared by the soft reset
  always_ff @(posedge clk) begin
    if (rst || por) begin
      cfg_q      <= '0;
      modem_q    <= '0;
      aux1_q     <= '0;
      tc_pulse_o <= 1'b0;
      acc_rdata  <= '0;
    end else begin
      if (wr_hit[SEL_CFG])   cfg_q   <= wbyte;
      if (wr_hit[SEL_MODEM]) modem_q <= wbyte;
      if (wr_hit[SEL_AUX1]) begin
        aux1_q              <= wbyte;
        aux1_q[AUX1_TC_BIT] <= 1'b0;
      end
      tc_pulse_o <= wr_hit[SEL_AUX1] & wbyte[AUX1_TC_BIT];
      if (rd_hit) acc_rdata <= rd_val;
    end
  end

  // registers kept across the soft reset
  always_ff @(posedge clk) begin
    if (por) begin
      diag_q       <= '0;
      led_q        <= '0;
      sysctl_q     <= '0;
      sysrst_req_o <= 1'b0;
    end else begin
      if (wr_hit[SEL_DIAG]) diag_q <= wbyte;
      if (wr_hit[SEL_LED])  led_q  <= acc_wdata[LED_W-1:0];
      if (wr_hit[SEL_SYSCTL] && wbyte[SYS_REQ_BIT]) sysctl_q <= SYS_STAT_VAL;
      sysrst_req_o <= !rst && wr_hit[SEL_SYSCTL] && wbyte[SYS_REQ_BIT];
    end
  end
endmodule

// File: rtl/aux_sysctl_chk.sv
module aux_sysctl_chk (
  input logic        clk,
  input logic        rst,
  input logic        por,
  input logic        acc_en,
  input logic        acc_wr,
  input logic [2:0]  acc_sel,
  input logic [1:0]  acc_off,
  input logic [31:0] acc_wdata,
  input logic        irq_o,
  input logic        tc_pulse_o,
  input logic        shutdown_req_o,
  input logic        sysrst_req_o,
  input logic [7:0]  cfg_q,
  input logic [7:0]  aux2_q,
  input logic [7:0]  aux1_q,
  input logic [7:0]  diag_q,
  input logic [7:0]  sysctl_q
);
  logic wr0;
  assign wr0 = acc_en && acc_wr && acc_off == 2'd0;

  // R8
  a_r8_irq_level: assert property (@(posedge clk) disable iff (rst || por)
    irq_o == (aux2_q[5] && cfg_q[3]));
  // R4
  a_r4_tc_pulse: assert property (@(posedge clk) disable iff (rst || por)
    (wr0 && acc_sel == 3'd5 && acc_wdata[1]) |=> tc_pulse_o);
  // R4
  a_r4_tc_not_kept: assert property (@(posedge clk) disable iff (rst || por)
    aux1_q[1] == 1'b0);
  // R5
  a_r5_aux2_bits: assert property (@(posedge clk) disable iff (rst || por)
    (aux2_q & 8'hDE) == 8'h00);
  // R6
  a_r6_shutdown: assert property (@(posedge clk) disable iff (rst || por)
    (wr0 && acc_sel == 3'd6 && acc_wdata[0]) |=> shutdown_req_o);
  // R9
  a_r9_sysctl_val: assert property (@(posedge clk) disable iff (por)
    sysctl_q == 8'h00 || sysctl_q == 8'h02);
  // R9
  a_r9_req_pulse: assert property (@(posedge clk) disable iff (rst || por)
    (wr0 && acc_sel == 3'd4 && acc_wdata[0]) |=> (sysrst_req_o && sysctl_q == 8'h02));
  // R10
  a_r10_keep: assert property (@(posedge clk) disable iff (por)
    rst |=> ($stable(diag_q) && $stable(sysctl_q)));
endmodule

bind aux_sysctl_regs aux_sysctl_chk u_chk (
  .clk(clk), .rst(rst), .por(por), .acc_en(acc_en), .acc_wr(acc_wr),
  .acc_sel(acc_sel), .acc_off(acc_off), .acc_wdata(acc_wdata),
  .irq_o(irq_o), .tc_pulse_o(tc_pulse_o), .shutdown_req_o(shutdown_req_o),
  .sysrst_req_o(sysrst_req_o), .cfg_q(cfg_q), .aux2_q(aux2_q),
  .aux1_q(aux1_q), .diag_q(diag_q), .sysctl_q(sysctl_q)
);

// File: tb/aux_sysctl_regs_bench.sv
module aux_sysctl_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        por = 1'b1;
  logic        acc_en = 1'b0;
  logic        acc_wr = 1'b0;
  logic [2:0]  acc_sel = 3'd0;
  logic [1:0]  acc_off = 2'd0;
  logic [31:0] acc_wdata = 32'd0;
  logic [31:0] acc_rdata;
  logic        pwr_fail_in = 1'b0;
  logic        irq_o, tc_pulse_o, shutdown_req_o, sysrst_req_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_sysctl_regs u_aux_sysctl_regs (
    .clk(clk), .rst(rst), .por(por), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_sel(acc_sel), .acc_off(acc_off), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .pwr_fail_in(pwr_fail_in), .irq_o(irq_o),
    .tc_pulse_o(tc_pulse_o), .shutdown_req_o(shutdown_req_o),
    .sysrst_req_o(sysrst_req_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // drive on a falling edge; returns at the next falling edge
  task automatic wr(input logic [2:0] s, input logic [1:0] o, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_sel = s; acc_off = o; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [1:0] o, output logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_sel = s; acc_off = o;
    @(negedge clk);
    acc_en = 1'b0;
    d = acc_rdata;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  m_aux2;
    logic [7:0]  e;
    repeat (3) @(negedge clk);
    por = 1'b0;

    // R11: power-on state
    for (int s = 0; s < 8; s++) begin
      rd(3'(s), 2'd0, r);
      chk("R11", "reg after por", r, 32'd0);
    end
    chk("R11", "irq after por", {31'd0, irq_o}, 32'd0);

    // R3 / R2: byte registers, every value
    for (int s = 0; s < 3; s++) begin
      for (int v = 0; v < 256; v++) begin
        wr(3'(s), 2'd0, {24'hABCDEF, 8'(v)});
        rd(3'(s), 2'd0, r);
        chk("R3", "byte readback", r, 32'(v));
      end
    end
    // R2: read data holds, a read has no side effect
    wr(3'd1, 2'd0, 32'h5A);
    rd(3'd1, 2'd0, r);
    cyc(); cyc();
    chk("R2", "rdata hold", acc_rdata, 32'h5A);
    rd(3'd1, 2'd0, r);
    chk("R2", "reread", r, 32'h5A);

    // R3: LED halfword
    for (int v = 0; v < 65536; v += 4099) begin
      wr(3'd3, 2'd0, {16'hFFFF, 16'(v)});
      rd(3'd3, 2'd0, r);
      chk("R3", "led readback", r, 32'(v));
    end
    // R1: non-zero offsets
    wr(3'd3, 2'd0, 32'h1234);
    wr(3'd3, 2'd1, 32'hBEEF);
    rd(3'd3, 2'd0, r);
    chk("R1", "led offset write ignored", r, 32'h1234);
    rd(3'd3, 2'd2, r);
    chk("R1", "led offset read zero", r, 32'd0);
    wr(3'd0, 2'd3, 32'h77);
    rd(3'd0, 2'd0, r);
    chk("R1", "cfg offset write ignored", r, 32'hFF);
    wr(3'd7, 2'd0, 32'hFF);
    rd(3'd7, 2'd0, r);
    chk("R1", "select 7 reads zero", r, 32'd0);

    // R4: aux1 sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd5, 2'd0, 32'(v));
      chk("R4", "tc pulse", {31'd0, tc_pulse_o}, 32'((v >> 1) & 1));
      cyc();
      chk("R4", "tc one cycle", {31'd0, tc_pulse_o}, 32'd0);
      rd(3'd5, 2'd0, r);
      chk("R4", "aux1 readback", r, 32'(v & 8'hFD));
    end

    // R7 / R8: power-fail with enable clear
    wr(3'd0, 2'd0, 32'h00);
    pwr_fail_in = 1'b1; cyc();
    cyc();
    rd(3'd6, 2'd0, r);
    chk("R7", "pf not latched when disabled", r, 32'd0);
    chk("R8", "irq off when disabled", {31'd0, irq_o}, 32'd0);
    // enable and produce a new change
    wr(3'd0, 2'd0, 32'h08);
    pwr_fail_in = 1'b0; cyc();
    pwr_fail_in = 1'b1; cyc();
    chk("R8", "irq raised", {31'd0, irq_o}, 32'd1);
    rd(3'd6, 2'd0, r);
    chk("R7", "pf latched", r, 32'h20);
    wr(3'd0, 2'd0, 32'h00);
    chk("R8", "irq masked by cfg", {31'd0, irq_o}, 32'd0);
    rd(3'd6, 2'd0, r);
    chk("R7", "pf kept while masked", r, 32'h20);
    wr(3'd0, 2'd0, 32'h08);
    chk("R8", "irq unmasked", {31'd0, irq_o}, 32'd1);
    wr(3'd6, 2'd0, 32'h02);
    chk("R8", "irq cleared", {31'd0, irq_o}, 32'd0);
    chk("R6", "no shutdown on clear", {31'd0, shutdown_req_o}, 32'd0);
    cyc(); cyc();
    rd(3'd6, 2'd0, r);
    chk("R7", "no relatch without change", r, 32'd0);

    // R5 / R6: aux2 sweep with periodic re-latch
    m_aux2 = 8'h00;
    for (int v = 0; v < 256; v++) begin
      if ((v % 16) == 0) begin
        pwr_fail_in = 1'b0; cyc();
        pwr_fail_in = 1'b1; cyc();
        m_aux2 = m_aux2 | 8'h20;
      end
      e = (8'(v) & 8'h03) | (m_aux2 & 8'h20);
      if (e[1]) e = e & 8'h01;
      wr(3'd6, 2'd0, 32'(v));
      chk("R6", "shutdown pulse", {31'd0, shutdown_req_o}, {31'd0, e[0]});
      chk("R8", "irq after aux2 write", {31'd0, irq_o}, {31'd0, e[5]});
      rd(3'd6, 2'd0, r);
      chk("R5", "aux2 readback", r, 32'(e));
      chk("R6", "shutdown one cycle", {31'd0, shutdown_req_o}, 32'd0);
      m_aux2 = e;
    end

    // R9: system control
    wr(3'd4, 2'd0, 32'hFFFF_FFFE);
    chk("R9", "no req bit0 clear", {31'd0, sysrst_req_o}, 32'd0);
    rd(3'd4, 2'd0, r);
    chk("R9", "unchanged bit0 clear", r, 32'd0);
    wr(3'd4, 2'd1, 32'h1);
    chk("R9", "no req at offset", {31'd0, sysrst_req_o}, 32'd0);
    rd(3'd4, 2'd0, r);
    chk("R9", "unchanged offset write", r, 32'd0);
    wr(3'd4, 2'd0, 32'h1);
    chk("R9", "reset request pulse", {31'd0, sysrst_req_o}, 32'd1);
    cyc();
    chk("R9", "request one cycle", {31'd0, sysrst_req_o}, 32'd0);
    rd(3'd4, 2'd0, r);
    chk("R9", "status stored", r, 32'h02);

    // R10: soft reset
    wr(3'd1, 2'd0, 32'hC3);
    wr(3'd2, 2'd0, 32'h3C);
    wr(3'd5, 2'd0, 32'h81);
    wr(3'd3, 2'd0, 32'h4321);
    @(negedge clk);
    rst = 1'b1;
    acc_en = 1'b1; acc_wr = 1'b1; acc_sel = 3'd1; acc_off = 2'd0; acc_wdata = 32'h11;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
    cyc();
    rst = 1'b0;
    chk("R10", "irq cleared", {31'd0, irq_o}, 32'd0);
    chk("R10", "rdata cleared", acc_rdata, 32'd0);
    rd(3'd0, 2'd0, r); chk("R10", "cfg cleared", r, 32'd0);
    rd(3'd2, 2'd0, r); chk("R10", "modem cleared", r, 32'd0);
    rd(3'd5, 2'd0, r); chk("R10", "aux1 cleared", r, 32'd0);
    rd(3'd6, 2'd0, r); chk("R10", "aux2 cleared", r, 32'd0);
    rd(3'd1, 2'd0, r); chk("R10", "diag kept, write ignored", r, 32'hC3);
    rd(3'd4, 2'd0, r); chk("R10", "sysctl kept", r, 32'h02);
    rd(3'd3, 2'd0, r); chk("R10", "led kept", r, 32'h4321);

    // R11: power-on reset clears the kept registers
    @(negedge clk); por = 1'b1;
    cyc();
    por = 1'b0;
    rd(3'd1, 2'd0, r); chk("R11", "diag cleared", r, 32'd0);
    rd(3'd4, 2'd0, r); chk("R11", "sysctl cleared", r, 32'd0);
    rd(3'd3, 2'd0, r); chk("R11", "led cleared", r, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule